// File: doc/BRIEF.md
# Pipeline Drain Handshake Controller

This controller quiets a multi-stage processor pipeline before the core is switched out or checkpointed. A drain command sends a one-cycle request pulse to every stage at once. The controller then gathers one "drained" acknowledgement from each stage and adds them up. Acknowledgements that arrive in the same cycle are summed together. When the running total equals the number of stages, the controller does three things: it drops the core clock-enable, moves to the Drained state, and raises a single-cycle completion pulse.

The stage agents sit inside the block. The middle stages (decode, rename, issue/execute/writeback) acknowledge as soon as they see the request. The fetch agent also acknowledges at once, but it raises a hold flag. While that flag is set, fetch may not start new cache-line requests and every returning instruction-cache response is dropped. The commit agent keeps its request pending until a cycle in which the reorder buffer is empty and no store is waiting to write back. It acknowledges in that cycle.

Three other commands are handled. A resume command restarts the core and clears every pending flag, unless the core has already been switched out. A switch-out command, taken only from Drained, flushes in-flight tracking and parks the core. A sleep command idles a running core, and a later drain wakes it again.

Top module: `pipe_drain_ctrl`

## Requirements
- R1: After synchronous reset the state code is 0 (Running), `core_tick_en` is 1, and `stage_drain_req`, `drain_done` and `flush_inflight` are 0. `fetch_req_allow` is 1.
- R2: A `drain_cmd` is accepted only in Running (0) or Idle (1) and only when no drain is in progress. An accepted command drives every bit of `stage_drain_req` high for exactly the following cycle. A `drain_cmd` given in any other situation leaves `stage_drain_req` at 0.
- R3: Accepting a drain while Idle sets the state code to 0 and `core_tick_en` to 1 in the following cycle.
- R4: The fetch agent (bit 0), the commit agent (bit NSTAGE-1) and every stage between them receive the request. The fetch and middle stages acknowledge in the request cycle. Commit acknowledges in the first cycle, from the request cycle onward, in which `rob_empty` is 1 and `stores_pending` is 0.
- R5: Acknowledgements are summed, and several can arrive in one cycle. In the cycle after the total reaches NSTAGE, `drain_done` is high for exactly one cycle, the state code is 2 (Drained) and `core_tick_en` is 0. The total never exceeds NSTAGE.
- R6: From the cycle after the request pulse until a resume, `fetch_req_allow` is 0 and `icache_keep` is 0 whatever `icache_resp_valid` is. At all other times `icache_keep` follows `icache_resp_valid`.
- R7: A `resume_cmd` given outside SwitchedOut sets, in the following cycle, the state code to 0 and `core_tick_en` to 1. It clears both pending flags and abandons any drain in progress, with no `drain_done` pulse. If a resume falls in the same cycle as drain completion, the resume wins.
- R8: In SwitchedOut (state code 3), `resume_cmd` is ignored: the state code stays 3 and `core_tick_en` stays 0.
- R9: A `switch_out_cmd` in Drained produces a one-cycle `flush_inflight` pulse in the following cycle, together with state code 3 and `core_tick_en` at 0. In any other state the command is ignored.
- R10: A `sleep_cmd` in Running with no drain in progress gives state code 1 and `core_tick_en` 0 in the following cycle. It is ignored while a drain is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drain_cmd | input | 1 | Start a drain |
| resume_cmd | input | 1 | Restart the core after a drain |
| switch_out_cmd | input | 1 | Park a drained core |
| sleep_cmd | input | 1 | Put a running core to idle |
| rob_empty | input | 1 | Reorder buffer holds no instructions |
| stores_pending | input | 1 | Stores still waiting to write back |
| icache_resp_valid | input | 1 | Instruction-cache response arriving |
| stage_drain_req | output | NSTAGE | Per-stage drain request pulse, bit 0 fetch, top bit commit |
| core_tick_en | output | 1 | Core clock-enable |
| core_state | output | 2 | 0 Running, 1 Idle, 2 Drained, 3 SwitchedOut |
| drain_done | output | 1 | One-cycle drain-complete pulse |
| flush_inflight | output | 1 | One-cycle pulse clearing in-flight instruction tracking |
| fetch_req_allow | output | 1 | Fetch may issue new cache-line requests |
| icache_keep | output | 1 | Arriving instruction-cache response is accepted |

## Verification
Two events can fall in the same cycle: the commit agent's late acknowledgement, which completes the drain, and a resume command. The bench withholds `rob_empty` until some cycles after the request, then raises it in the same cycle as `resume_cmd`. It then checks that no `drain_done` pulse appears, that the state returns to Running with the tick enabled, and that a later empty reorder buffer still produces no completion. A sweep over how long commit is held back, caused either by a non-empty reorder buffer or by pending stores, checks that completion arrives exactly one cycle after the last acknowledgement.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_IDLE    = 2'd1,
    ST_DRAINED = 2'd2,
    ST_SWOUT   = 2'd3
  } core_state_t;
endpackage

// File: rtl/pdc_fetch_agent.sv
module pdc_fetch_agent (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic clr,
  input  logic resp_valid,
  output logic ack,
  output logic resp_keep,
  output logic line_req_allow
);
  logic hold_q;

  // Fetch has no in-flight state that must settle, so it acknowledges at once.
  assign ack = req;

  always_ff @(posedge clk) begin
    if (rst)      hold_q <= 1'b0;
    else if (clr) hold_q <= 1'b0;
    else if (req) hold_q <= 1'b1;
  end

  assign resp_keep      = resp_valid & ~hold_q;
  assign line_req_allow = ~hold_q;

  // R6
  fetch_drop_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (!resp_keep && !line_req_allow));
endmodule

// File: rtl/pdc_commit_agent.sv
module pdc_commit_agent (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic clr,
  input  logic rob_empty,
  input  logic stores_pending,
  output logic ack
);
  logic pend_q;
  logic quiet;

  assign quiet = rob_empty & ~stores_pending;
  assign ack   = (req | pend_q) & quiet & ~clr;

  always_ff @(posedge clk) begin
    if (rst)      pend_q <= 1'b0;
    else if (clr) pend_q <= 1'b0;
    else          pend_q <= (req | pend_q) & ~ack;
  end

  // R4
  commit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (rob_empty && !stores_pending));
endmodule

// File: rtl/pdc_ack_tally.sv
module pdc_ack_tally #(
  parameter int NSTAGE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [NSTAGE-1:0] acks,
  output logic              reach
);
  localparam int CW = $clog2(NSTAGE + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q};
    for (int i = 0; i < NSTAGE; i++) sum = sum + (CW+1)'(acks[i]);
  end

  assign reach = en && (sum == (CW+1)'(NSTAGE));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= sum[CW-1:0];
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(NSTAGE));
endmodule

// File: rtl/pipe_drain_ctrl.sv
module pipe_drain_ctrl #(
  parameter int NSTAGE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drain_cmd,
  input  logic              resume_cmd,
  input  logic              switch_out_cmd,
  input  logic              sleep_cmd,
  input  logic              rob_empty,
  input  logic              stores_pending,
  input  logic              icache_resp_valid,
  output logic [NSTAGE-1:0] stage_drain_req,
  output logic              core_tick_en,
  output logic [1:0]        core_state,
  output logic              drain_done,
  output logic              flush_inflight,
  output logic              fetch_req_allow,
  output logic              icache_keep
);
  import pdc_pkg::*;

  localparam int FETCH_IDX  = 0;
  localparam int COMMIT_IDX = NSTAGE - 1;

  core_state_t       state_q;
  logic              tick_q, draining_q, req_q, done_q, flush_q;
  logic [NSTAGE-1:0] acks;
  logic              reach;
  logic              do_swout, do_resume, do_drain, do_sleep;

  // Command priority: switch-out, resume, drain start, completion, sleep.
  assign do_swout  = switch_out_cmd && (state_q == ST_DRAINED);
  assign do_resume = !do_swout && resume_cmd && (state_q != ST_SWOUT);
  assign do_drain  = !do_swout && !do_resume && drain_cmd && !draining_q &&
                     ((state_q == ST_RUN) || (state_q == ST_IDLE));
  assign do_sleep  = sleep_cmd && (state_q == ST_RUN) && !draining_q;

  pdc_fetch_agent u_fetch (
    .clk(clk), .rst(rst), .req(req_q), .clr(do_resume),
    .resp_valid(icache_resp_valid), .ack(acks[FETCH_IDX]),
    .resp_keep(icache_keep), .line_req_allow(fetch_req_allow)
  );

  generate
    for (genvar s = 1; s < COMMIT_IDX; s++) begin : g_mid
      assign acks[s] = req_q;
    end
  endgenerate

  pdc_commit_agent u_commit (
    .clk(clk), .rst(rst), .req(req_q), .clr(do_resume),
    .rob_empty(rob_empty), .stores_pending(stores_pending),
    .ack(acks[COMMIT_IDX])
  );

  pdc_ack_tally #(.NSTAGE(NSTAGE)) u_tally (
    .clk(clk), .rst(rst), .clr(do_drain), .en(draining_q),
    .acks(acks), .reach(reach)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      tick_q     <= 1'b1;
      draining_q <= 1'b0;
      req_q      <= 1'b0;
      done_q     <= 1'b0;
      flush_q    <= 1'b0;
    end else begin
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      if (do_swout) begin
        state_q <= ST_SWOUT;
        tick_q  <= 1'b0;
        flush_q <= 1'b1;
      end else if (do_resume) begin
        state_q    <= ST_RUN;
        tick_q     <= 1'b1;
        draining_q <= 1'b0;
      end else if (do_drain) begin
        state_q    <= ST_RUN;
        tick_q     <= 1'b1;
        draining_q <= 1'b1;
        req_q      <= 1'b1;
      end else if (reach) begin
        state_q    <= ST_DRAINED;
        tick_q     <= 1'b0;
        draining_q <= 1'b0;
        done_q     <= 1'b1;
      end else if (do_sleep) begin
        state_q <= ST_IDLE;
        tick_q  <= 1'b0;
      end
    end
  end

  assign stage_drain_req = {NSTAGE{req_q}};
  assign core_tick_en    = tick_q;
  assign core_state      = state_q;
  assign drain_done      = done_q;
  assign flush_inflight  = flush_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    drain_done |=> !drain_done);
  // R5
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> (core_state == 2'd2 && !core_tick_en));
  // R8
  swout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (core_state == 2'd3) |=> (core_state == 2'd3 && !core_tick_en));
  // R9
  flush_state_chk: assert property (@(posedge clk) disable iff (rst)
    flush_inflight |-> (core_state == 2'd3));
endmodule

// File: tb/pipe_drain_ctrl_tb.sv
module pipe_drain_ctrl_tb;
  localparam int NSTAGE = 5;
  localparam logic [NSTAGE-1:0] ALL = {NSTAGE{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drain_cmd = 0, resume_cmd = 0, switch_out_cmd = 0, sleep_cmd = 0;
  logic rob_empty = 1, stores_pending = 0, icache_resp_valid = 0;
  logic [NSTAGE-1:0] stage_drain_req;
  logic core_tick_en, drain_done, flush_inflight, fetch_req_allow, icache_keep;
  logic [1:0] core_state;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pipe_drain_ctrl #(.NSTAGE(NSTAGE)) u_dut (
    .clk(clk), .rst(rst), .drain_cmd(drain_cmd), .resume_cmd(resume_cmd),
    .switch_out_cmd(switch_out_cmd), .sleep_cmd(sleep_cmd),
    .rob_empty(rob_empty), .stores_pending(stores_pending),
    .icache_resp_valid(icache_resp_valid), .stage_drain_req(stage_drain_req),
    .core_tick_en(core_tick_en), .core_state(core_state),
    .drain_done(drain_done), .flush_inflight(flush_inflight),
    .fetch_req_allow(fetch_req_allow), .icache_keep(icache_keep)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; drain_cmd = 0; resume_cmd = 0; switch_out_cmd = 0; sleep_cmd = 0;
    rob_empty = 1; stores_pending = 0; icache_resp_valid = 0;
    nxt(); nxt();
    rst = 0;
  endtask

  task automatic do_resume();
    resume_cmd = 1; nxt(); resume_cmd = 0;
  endtask

  // Drain with commit held back d cycles after the request by rob or stores.
  task automatic drain_sweep(input int d, input bit by_stores);
    drain_cmd = 1; rob_empty = by_stores; stores_pending = 0;
    nxt();
    drain_cmd = 0;
    chk("R2 req pulse", int'(stage_drain_req == ALL), 1);
    for (int j = 0; j <= d; j++) begin
      if (by_stores) stores_pending = (j < d);
      else           rob_empty = (j >= d);
      nxt();
      if (j > 0) chk("R6 fetch hold", int'(fetch_req_allow), 0);
      chk("R5 done timing", int'(drain_done), int'(j == d));
      if (j < d) chk("R4 commit waits", int'(core_state), 0);
    end
    stores_pending = 0; rob_empty = 1;
    chk("R5 drained state", int'(core_state), 2);
    chk("R5 tick off", int'(core_tick_en), 0);
    icache_resp_valid = 1;
    nxt();
    chk("R5 done single", int'(drain_done), 0);
    chk("R6 resp dropped", int'(icache_keep), 0);
    do_resume();
    chk("R7 state run", int'(core_state), 0);
    chk("R7 tick on", int'(core_tick_en), 1);
    chk("R7 fetch allow", int'(fetch_req_allow), 1);
    chk("R6 resp kept", int'(icache_keep), 1);
    icache_resp_valid = 0;
  endtask

  initial begin
    do_reset();
    nxt();
    chk("R1 state", int'(core_state), 0);
    chk("R1 tick", int'(core_tick_en), 1);
    chk("R1 req", int'(stage_drain_req), 0);
    chk("R1 done", int'(drain_done), 0);
    chk("R1 flush", int'(flush_inflight), 0);
    chk("R1 allow", int'(fetch_req_allow), 1);

    // R9: switch-out ignored while running
    switch_out_cmd = 1; nxt(); switch_out_cmd = 0;
    chk("R9 ignored state", int'(core_state), 0);
    chk("R9 ignored flush", int'(flush_inflight), 0);

    for (int d = 0; d < 6; d++) begin
      drain_sweep(d, 0);
      drain_sweep(d, 1);
    end

    // R2: repeated drain while draining is ignored; R10: sleep ignored
    drain_cmd = 1; rob_empty = 0; nxt();
    sleep_cmd = 1; nxt();
    drain_cmd = 0; sleep_cmd = 0;
    chk("R2 no re-request", int'(stage_drain_req), 0);
    chk("R10 sleep ignored", int'(core_state), 0);
    chk("R10 tick stays", int'(core_tick_en), 1);
    rob_empty = 1; nxt();
    chk("R5 done after ignore", int'(drain_done), 1);
    do_resume();

    // R7: resume in same cycle as completion wins
    drain_cmd = 1; rob_empty = 0; nxt();
    drain_cmd = 0; nxt();
    rob_empty = 1; resume_cmd = 1; nxt();
    resume_cmd = 0;
    chk("R7 no done", int'(drain_done), 0);
    chk("R7 run", int'(core_state), 0);
    chk("R7 tick", int'(core_tick_en), 1);
    nxt();
    chk("R7 abandoned", int'(drain_done), 0);
    chk("R7 stays run", int'(core_state), 0);

    // R10 sleep, R3 wake by drain
    sleep_cmd = 1; nxt(); sleep_cmd = 0;
    chk("R10 idle", int'(core_state), 1);
    chk("R10 tick off", int'(core_tick_en), 0);
    drain_cmd = 1; rob_empty = 1; nxt(); drain_cmd = 0;
    chk("R3 wake state", int'(core_state), 0);
    chk("R3 wake tick", int'(core_tick_en), 1);
    chk("R2 req from idle", int'(stage_drain_req == ALL), 1);
    nxt();
    chk("R5 done from idle", int'(drain_done), 1);

    // R9 switch-out from drained, R8 resume ignored, R2 drain ignored
    switch_out_cmd = 1; nxt(); switch_out_cmd = 0;
    chk("R9 flush", int'(flush_inflight), 1);
    chk("R9 state", int'(core_state), 3);
    chk("R9 tick", int'(core_tick_en), 0);
    nxt();
    chk("R9 flush single", int'(flush_inflight), 0);
    do_resume();
    chk("R8 state", int'(core_state), 3);
    chk("R8 tick", int'(core_tick_en), 0);
    drain_cmd = 1; nxt(); drain_cmd = 0;
    chk("R2 ignored swout", int'(stage_drain_req), 0);
    chk("R8 state kept", int'(core_state), 3);

    do_reset();
    nxt();
    chk("R1 after reset", int'(core_state), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule